// File: doc/BRIEF.md
# Programmable YUV-to-RGB Matrix Converter

This block turns a stream of luma/chroma pixels into RGB, one pixel per clock. Each output channel comes from its own row of a 3x4 matrix: three signed multipliers applied to the luma and two chroma inputs, plus one signed offset added to the sum. The twelve matrix words and a small control word are written through a simple register write port. When the control word's enable bit is clear, pixels flow through with the same latency and are not changed.

A write never touches the live matrix directly. Every write lands in a staging copy. The whole staging copy (matrix and control) moves into the live copy on a frame-start pulse, so one frame is never converted with a mix of old and new settings. A chroma-swap control bit lets the same matrix serve inputs that carry the two chroma components in the opposite order. It works by exchanging the coefficients that multiply the two chroma inputs.

Top module: `yuv_rgb_matrix`

## Requirements
- R1: Each output channel equals (m0*Y + m1*U + m2*V + k + 512) shifted arithmetically right by 10. Here m0, m1, m2 and k are the 32-bit two's-complement words of that channel's row, with 10 fractional bits (0x400 is 1.0). The inputs Y, U and V are unsigned 8-bit values, and the rounding therefore goes half upward.
- R2: A result below 0 is output as 0, and a result above 255 is output as 255.
- R3: Register addresses 0 to 11 hold the matrix row by row, four words per row in the order m0, m1, m2, k. Row 0 drives out_r, row 1 drives out_g and row 2 drives out_b. Address 12 is the control word: bit 0 is enable and bit 1 is chroma swap.
- R4: With chroma swap set, each row uses its m2 word for U and its m1 word for V.
- R5: With enable clear, out_r, out_g and out_b equal the in_y, in_u and in_v of the same pixel.
- R6: out_valid and out_side repeat in_valid and in_side exactly 3 clock cycles later. The pixel result appears in that same cycle.
- R7: Writes change only the staging copy. The live matrix and control move from the staging copy only in a cycle where frame_start is high. The pixel presented in that same cycle already uses the new settings.
- R8: After reset, out_valid is 0, the block is disabled, and all matrix words are zero.
- R9: Writes to addresses 13 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame-start pulse that loads the staged settings |
| in_valid | input | 1 | Input pixel valid |
| in_y | input | 8 | Luma |
| in_u | input | 8 | First chroma component |
| in_v | input | 8 | Second chroma component |
| in_side | input | SIDE_W (4) | Sideband that travels with the pixel |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |
| out_side | output | SIDE_W (4) | Delayed sideband |

## Verification
The stimulus runs in this order:
- A pass-through pixel while disabled, which shows the reset state and also the bypass path.
- An identity matrix fed a back-to-back stream, which isolates latency and row-to-channel mapping from the arithmetic.
- A half-gain matrix on odd inputs, which tells round-half-up apart from truncation.
- A video-style matrix with negative terms at the colour-cube corners, which drives both clamp limits.

The same matrix is then run again with the swap bit set, which tells the exchanged chroma columns apart from the plain order. The staging tests write without a frame pulse and then pulse frame_start together with a pixel. These show when a write takes effect and which settings the boundary pixel uses.

// File: rtl/yrm_pkg.sv
package yrm_pkg;
    parameter int unsigned PIX_W    = 8;
    parameter int unsigned COEF_W   = 32;
    parameter int unsigned FRAC_W   = 10;
    parameter int unsigned ACC_W    = 48;
    parameter int unsigned NROW     = 3;
    parameter int unsigned ROW_REGS = 4;
    parameter int unsigned NREG     = NROW * ROW_REGS;
    parameter int unsigned ADDR_W   = 4;
    parameter int unsigned CTRL_ADDR = NREG;
    parameter int unsigned EN_BIT   = 0;
    parameter int unsigned SWAP_BIT = 1;
    parameter int unsigned PIX_MAX  = (1 << PIX_W) - 1;
    parameter int unsigned LATENCY  = 3;

    typedef logic        [PIX_W-1:0]  pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    // one output row: three multipliers and the trailing offset
    typedef struct packed {
        coef_t m0;
        coef_t m1;
        coef_t m2;
        coef_t k;
    } row_cfg_t;

    typedef struct packed {
        logic en;
        logic swap;
    } ctrl_t;

    localparam int unsigned ROW_BITS  = $bits(row_cfg_t);
    localparam int unsigned FLAT_W    = NROW * ROW_BITS + $bits(ctrl_t);
endpackage

// File: rtl/yrm_cfg_bank.sv
module yrm_cfg_bank
    import yrm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [COEF_W-1:0]        wr_data,
    input  logic                     frame_start,
    output row_cfg_t [NROW-1:0]      pend_rows,
    output row_cfg_t [NROW-1:0]      act_rows,
    output ctrl_t                    pend_ctl,
    output ctrl_t                    act_ctl
);
    typedef struct packed {
        row_cfg_t [NROW-1:0] pend;
        row_cfg_t [NROW-1:0] act;
        ctrl_t               pctl;
        ctrl_t               actl;
    } bank_t;

    localparam int unsigned ROW_IDX_W = ADDR_W - 2;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (wr_addr < ADDR_W'(NREG)) begin
                for (int r = 0; r < int'(NROW); r++) begin
                    if (wr_addr[ADDR_W-1:2] == ROW_IDX_W'(r)) begin
                        case (wr_addr[1:0])
                            2'd0:    s_d.pend[r].m0 = coef_t'(wr_data);
                            2'd1:    s_d.pend[r].m1 = coef_t'(wr_data);
                            2'd2:    s_d.pend[r].m2 = coef_t'(wr_data);
                            default: s_d.pend[r].k  = coef_t'(wr_data);
                        endcase
                    end
                end
            end else if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
                s_d.pctl.en   = wr_data[EN_BIT];
                s_d.pctl.swap = wr_data[SWAP_BIT];
            end
        end
        // staged settings go live only at a frame boundary
        if (frame_start) begin
            s_d.act  = s_q.pend;
            s_d.actl = s_q.pctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_rows = s_q.pend;
    assign act_rows  = s_q.act;
    assign pend_ctl  = s_q.pctl;
    assign act_ctl   = s_q.actl;
endmodule

// File: rtl/yrm_row.sv
module yrm_row
    import yrm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  row_cfg_t cfg,
    input  logic     en,
    input  pix_t     x0,
    input  pix_t     x1,
    input  pix_t     x2,
    input  pix_t     pass,
    output pix_t     y
);
    localparam acc_t RND = acc_t'(1) <<< (FRAC_W - 1);

    typedef struct packed {
        acc_t p0;
        acc_t p1;
        acc_t p2;
        acc_t k1;
        logic en1;
        pix_t pass1;
        acc_t sum;
        logic en2;
        pix_t pass2;
        pix_t y3;
    } row_st_t;

    row_st_t s_d, s_q;

    function automatic acc_t mul(pix_t x, coef_t c);
        acc_t xe;
        acc_t ce;
        xe = acc_t'({1'b0, x});
        ce = acc_t'(c);
        return xe * ce;
    endfunction

    function automatic pix_t sat(acc_t a);
        acc_t s;
        s = a >>> FRAC_W;
        if (s < 0)                   return '0;
        else if (s > acc_t'(PIX_MAX)) return pix_t'(PIX_MAX);
        else                         return s[PIX_W-1:0];
    endfunction

    always_comb begin
        s_d = s_q;
        // stage 1: products
        s_d.p0    = mul(x0, cfg.m0);
        s_d.p1    = mul(x1, cfg.m1);
        s_d.p2    = mul(x2, cfg.m2);
        s_d.k1    = acc_t'(cfg.k);
        s_d.en1   = en;
        s_d.pass1 = pass;
        // stage 2: sum, offset, rounding bias
        s_d.sum   = $signed(s_q.p0) + $signed(s_q.p1) + $signed(s_q.p2)
                  + $signed(s_q.k1) + RND;
        s_d.en2   = s_q.en1;
        s_d.pass2 = s_q.pass1;
        // stage 3: scale, saturate or bypass
        s_d.y3    = s_q.en2 ? sat($signed(s_q.sum)) : s_q.pass2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign y = s_q.y3;
endmodule

// File: rtl/yuv_rgb_matrix.sv
module yuv_rgb_matrix
    import yrm_pkg::*;
#(
    parameter int unsigned SIDE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_y,
    input  logic [PIX_W-1:0]  in_u,
    input  logic [PIX_W-1:0]  in_v,
    input  logic [SIDE_W-1:0] in_side,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b,
    output logic [SIDE_W-1:0] out_side
);
    row_cfg_t [NROW-1:0] pend_rows, act_rows, use_rows, eff_rows;
    ctrl_t               pend_ctl, act_ctl, use_ctl;
    logic                use_en;
    logic [FLAT_W-1:0]   act_flat, pend_flat;
    pix_t [NROW-1:0]     comp_in, comp_out;

    yrm_cfg_bank u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wdata),
        .frame_start (frame_start),
        .pend_rows   (pend_rows),
        .act_rows    (act_rows),
        .pend_ctl    (pend_ctl),
        .act_ctl     (act_ctl)
    );

    // the pixel arriving with frame_start already sees the staged settings
    assign use_rows = frame_start ? pend_rows : act_rows;
    assign use_ctl  = frame_start ? pend_ctl  : act_ctl;
    assign use_en   = use_ctl.en;

    assign act_flat  = {act_rows, act_ctl};
    assign pend_flat = {pend_rows, pend_ctl};

    assign comp_in[0] = in_y;
    assign comp_in[1] = in_u;
    assign comp_in[2] = in_v;

    for (genvar r = 0; r < NROW; r++) begin : g_row
        always_comb begin
            eff_rows[r].m0 = use_rows[r].m0;
            eff_rows[r].k  = use_rows[r].k;
            if (use_ctl.swap) begin
                eff_rows[r].m1 = use_rows[r].m2;
                eff_rows[r].m2 = use_rows[r].m1;
            end else begin
                eff_rows[r].m1 = use_rows[r].m1;
                eff_rows[r].m2 = use_rows[r].m2;
            end
        end

        yrm_row u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (eff_rows[r]),
            .en    (use_en),
            .x0    (in_y),
            .x1    (in_u),
            .x2    (in_v),
            .pass  (comp_in[r]),
            .y     (comp_out[r])
        );
    end

    // valid and sideband delay line, matched to the row pipeline
    typedef struct packed {
        logic [LATENCY-1:0]             v;
        logic [LATENCY-1:0][SIDE_W-1:0] s;
    } side_pipe_t;

    side_pipe_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        p_d.v[0] = in_valid;
        p_d.s[0] = in_side;
        for (int i = 1; i < int'(LATENCY); i++) begin
            p_d.v[i] = p_q.v[i-1];
            p_d.s[i] = p_q.s[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_valid = p_q.v[LATENCY-1];
    assign out_side  = p_q.s[LATENCY-1];
    assign out_r     = comp_out[0];
    assign out_g     = comp_out[1];
    assign out_b     = comp_out[2];
endmodule

// File: rtl/yrm_matrix_chk.sv
module yrm_matrix_chk
    import yrm_pkg::*;
#(
    parameter int unsigned SIDE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              in_valid,
    input logic [PIX_W-1:0]  in_y,
    input logic [PIX_W-1:0]  in_u,
    input logic [PIX_W-1:0]  in_v,
    input logic [SIDE_W-1:0] in_side,
    input logic              use_en,
    input logic [FLAT_W-1:0] act_flat,
    input logic [FLAT_W-1:0] pend_flat,
    input logic              out_valid,
    input logic [PIX_W-1:0]  out_r,
    input logic [PIX_W-1:0]  out_g,
    input logic [PIX_W-1:0]  out_b,
    input logic [SIDE_W-1:0] out_side
);
    logic [1:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd3);

    // R6
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> out_valid == $past(in_valid, 3));

    // R6
    side_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid) |-> out_side == $past(in_side, 3));

    // R5
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && !$past(use_en, 3))
            |-> {out_r, out_g, out_b} == $past({in_y, in_u, in_v}, 3));

    // R7
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_flat));

    // R7
    live_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> act_flat == $past(pend_flat));
endmodule

bind yuv_rgb_matrix yrm_matrix_chk #(.SIDE_W(SIDE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_y        (in_y),
    .in_u        (in_u),
    .in_v        (in_v),
    .in_side     (in_side),
    .use_en      (use_en),
    .act_flat    (act_flat),
    .pend_flat   (pend_flat),
    .out_valid   (out_valid),
    .out_r       (out_r),
    .out_g       (out_g),
    .out_b       (out_b),
    .out_side    (out_side)
);

// File: tb/yuv_rgb_matrix_test.sv
`timescale 1ns/1ps
module yuv_rgb_matrix_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
    logic [3:0]  in_side = '0;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b;
    logic [3:0]  out_side;

    int total = 0;
    int bad = 0;

    // requirement-level model of the register state
    int cp [12];
    int ca [12];
    bit pen = 0, psw = 0, aen = 0, asw = 0;

    int py [8], pu [8], pv [8];

    always #2.5 clk = ~clk;

    yuv_rgb_matrix uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_y(in_y), .in_u(in_u), .in_v(in_v), .in_side(in_side),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .out_side(out_side)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_row(int r, int y, int u, int v);
        longint m0, m1, m2, k, acc, t;
        m0 = ca[r*4]; m1 = ca[r*4+1]; m2 = ca[r*4+2]; k = ca[r*4+3];
        if (asw) begin t = m1; m1 = m2; m2 = t; end
        acc = m0*y + m1*u + m2*v + k + 512;
        acc = acc >>> 10;
        if (acc < 0)   return 0;
        if (acc > 255) return 255;
        return int'(acc);
    endfunction

    function automatic int expect_ch(int r, int y, int u, int v);
        if (!aen) return (r == 0) ? y : (r == 1) ? u : v;
        return ref_row(r, y, u, v);
    endfunction

    task automatic wr(int addr, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 32'(data);
        if (addr < 12) cp[addr] = data;
        else if (addr == 12) begin pen = data[0]; psw = data[1]; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_model_live();
        for (int i = 0; i < 12; i++) ca[i] = cp[i];
        aen = pen; asw = psw;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        load_model_live();
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic write_matrix(int m[12]);
        for (int i = 0; i < 12; i++) wr(i, m[i]);
    endtask

    // one pixel, optionally with frame_start; result sampled three edges on
    task automatic one_px(int y, int u, int v, int side, bit with_frame, string req);
        int er, eg, eb;
        @(negedge clk);
        if (with_frame) begin frame_start = 1'b1; load_model_live(); end
        in_valid = 1'b1; in_y = 8'(y); in_u = 8'(u); in_v = 8'(v); in_side = 4'(side);
        er = expect_ch(0, y, u, v); eg = expect_ch(1, y, u, v); eb = expect_ch(2, y, u, v);
        @(negedge clk);
        frame_start = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid === 1'b1, req, "out_valid", int'(out_valid), 1);
        chk(out_r == 8'(er), req, "out_r", int'(out_r), er);
        chk(out_g == 8'(eg), req, "out_g", int'(out_g), eg);
        chk(out_b == 8'(eb), req, "out_b", int'(out_b), eb);
        chk(out_side == 4'(side), req, "out_side", int'(out_side), side);
    endtask

    // back-to-back stream of n pixels from py/pu/pv
    task automatic stream(int n, string req);
        int er [8], eg [8], eb [8];
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk(out_valid === 1'b1, req, "stream valid", int'(out_valid), 1);
                chk(out_r == 8'(er[i-3]), req, "stream r", int'(out_r), er[i-3]);
                chk(out_g == 8'(eg[i-3]), req, "stream g", int'(out_g), eg[i-3]);
                chk(out_b == 8'(eb[i-3]), req, "stream b", int'(out_b), eb[i-3]);
                chk(out_side == 4'(i-3), req, "stream side", int'(out_side), i-3);
            end else begin
                chk(out_valid === 1'b0, req, "stream idle", int'(out_valid), 0);
            end
            if (i < n) begin
                in_valid = 1'b1;
                in_y = 8'(py[i]); in_u = 8'(pu[i]); in_v = 8'(pv[i]); in_side = 4'(i);
                er[i] = expect_ch(0, py[i], pu[i], pv[i]);
                eg[i] = expect_ch(1, py[i], pu[i], pv[i]);
                eb[i] = expect_ch(2, py[i], pu[i], pv[i]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(out_valid === 1'b0, req, "stream drains", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        chk(out_valid === 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_bypass();
        // R8 and R5: reset leaves the block disabled
        one_px(10, 200, 77, 5, 1'b0, "R5");
        one_px(255, 0, 128, 9, 1'b0, "R8");
    endtask

    task automatic t_bad_addr();
        // R9: addresses 13..15 must not enable anything
        wr(13, 3); wr(14, 3); wr(15, -1);
        frame();
        one_px(40, 90, 140, 3, 1'b0, "R9");
    endtask

    task automatic t_identity();
        int m[12] = '{1024,0,0,0, 0,1024,0,0, 0,0,1024,0};
        write_matrix(m); wr(12, 1); frame();
        py = '{0, 17, 128, 255, 64, 3, 200, 99};
        pu = '{255, 34, 128, 0, 1, 250, 7, 100};
        pv = '{9, 51, 128, 255, 2, 60, 180, 101};
        stream(8, "R6");   // R3 mapping of rows to channels also checked here
    endtask

    task automatic t_rounding();
        int m[12] = '{512,0,0,0, 0,512,0,0, 0,0,512,0};
        write_matrix(m); frame();
        // R1: half gain, literal round-half-up results 1, 2, 3
        @(negedge clk);
        in_valid = 1'b1; in_y = 8'd1; in_u = 8'd3; in_v = 8'd5; in_side = 4'd1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(out_r == 8'd1, "R1", "round 0.5", int'(out_r), 1);
        chk(out_g == 8'd2, "R1", "round 1.5", int'(out_g), 2);
        chk(out_b == 8'd3, "R1", "round 2.5", int'(out_b), 3);
    endtask

    task automatic t_video();
        int m[12] = '{1024, 0, 1436, -183808,
                      1024, -352, -731, 138752,
                      1024, 1814, 0, -232320};
        write_matrix(m); frame();
        py = '{255, 0, 128, 81, 16, 235, 200, 50};
        pu = '{128, 128, 128, 90, 255, 0, 30, 220};
        pv = '{255, 0, 128, 240, 255, 0, 220, 40};
        stream(8, "R1");
        // R2: literal clamp corners
        one_px(255, 128, 255, 2, 1'b0, "R2");
        chk(out_r == 8'd255, "R2", "high clamp", int'(out_r), 255);
        one_px(0, 128, 0, 2, 1'b0, "R2");
        chk(out_r == 8'd0, "R2", "low clamp", int'(out_r), 0);
    endtask

    task automatic t_swap();
        wr(12, 3); frame();
        one_px(100, 200, 30, 6, 1'b0, "R4");
        one_px(60, 20, 240, 7, 1'b0, "R4");
    endtask

    task automatic t_staging();
        int m[12] = '{1024,0,0,0, 0,1024,0,0, 0,0,1024,0};
        write_matrix(m); wr(12, 1);
        // R7: no frame pulse yet, swapped video matrix stays live
        one_px(100, 200, 30, 4, 1'b0, "R7");
        frame();
        one_px(100, 200, 30, 4, 1'b0, "R7");
        chk(out_r == 8'd100, "R7", "identity after frame", int'(out_r), 100);
    endtask

    task automatic t_frame_pixel();
        int m[12] = '{512,0,0,0, 0,512,0,0, 0,0,512,0};
        write_matrix(m);
        // R7: pixel presented with frame_start uses the new matrix
        one_px(201, 101, 51, 8, 1'b1, "R7");
        chk(out_r == 8'd101, "R7", "boundary pixel", int'(out_r), 101);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) begin cp[i] = 0; ca[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_bad_addr();
        t_identity();
        t_rounding();
        t_video();
        t_swap();
        t_staging();
        t_frame_pixel();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule